// File: doc/BRIEF.md
# Dual-Bank Window Stream Reader

This block keeps a stored image in an on-chip buffer and plays back a rectangular window of it as a video stream that carries two 16-bit pixels on every beat. The buffer is split between two banks by the lowest bit of the linear pixel address. Two neighbouring pixels therefore always sit in different banks and can be fetched in the same cycle, whatever the window offset.

A simple write port loads the image one pixel at a time. The window is set on configuration inputs: a line count, a pixel count per line, a start row and a start column. A one-cycle start pulse copies these values and begins a frame. The output follows the AXI4-Stream handshake. A user flag marks the first beat of the frame and a last flag marks the final beat of each line. A one-cycle done pulse follows the final handshake of the frame.

Top module: `fbr_reader`

## Requirements
- R1: After reset, outValid and done are low and stay low until a start pulse arrives.
- R2: Each beat packs two pixels. The pixel at the lower linear address goes in bits 15:0 and the pixel at the next address goes in bits 31:16. A pixel written at linear address a with wrEn is the value read back for address a.
- R3: The beat for window row y and column x, where x advances by two per beat, reads linear address (y + cfgStartRow) × MAX_WIDTH + x + cfgStartCol. Lines are emitted in increasing y. Within a line, beats are emitted in increasing x.
- R4: When that linear address is odd, the lower pixel comes from the odd bank and the upper pixel comes from the even bank at the next word, so the packing of R2 still holds.
- R5: outUser is high on the first beat of the frame (y = 0, x = 0) and low on every other beat.
- R6: outLast is high on the beat where x = cfgPixels − 2 and low on every other beat.
- R7: While outReady stays high, the block delivers one beat per clock with no gaps, including across line boundaries, so a frame of L lines and P pixels takes L·P/2 consecutive cycles.
- R8: While outValid is high and outReady is low, outData, outUser and outLast hold their values and outValid stays high.
- R9: done is a single-cycle pulse. It is raised in the cycle after the last beat of the last line is accepted, and no beat is presented after it.
- R10: A start pulse that arrives while a frame is in progress is ignored. The running frame keeps its settings and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Pixel write strobe |
| wrAddr | input | ADDR_W (9) | Linear pixel address for the write |
| wrData | input | PIX_W (16) | Pixel value to store |
| start | input | 1 | Begin a frame with the current configuration |
| cfgLines | input | LINES_W (10) | Window height in lines |
| cfgPixels | input | PIXELS_W (11) | Window width in pixels (even) |
| cfgStartRow | input | LINES_W (10) | First buffer row of the window |
| cfgStartCol | input | PIXELS_W (11) | First buffer column of the window |
| outData | output | 2·PIX_W (32) | Pixel pair |
| outValid | output | 1 | Beat valid |
| outReady | input | 1 | Sink accepts the beat |
| outUser | output | 1 | First beat of the frame |
| outLast | output | 1 | Final beat of the line |
| done | output | 1 | Frame finished pulse |

## Verification
The assertions take three things for granted about the inputs. The sink follows the stream handshake. The window has at least one line and an even pixel count of at least two. The window lies fully inside the buffer, including the extra pixel that an odd start column reaches. The bench programs only windows that meet these conditions. It also leaves the write port idle while a frame plays, so readback never races a load. Its ready pattern either stays high throughout or comes from a free-running shift register, which produces stalls of varied length in every part of the line.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } fbrState_t;

  // strobes from control to datapath, valid in the current cycle
  typedef struct packed {
    logic advance;    // output register may take a new value
    logic issue;      // a beat is read from the banks this cycle
    logic firstBeat;  // the issued beat opens the frame
    logic lineEnd;    // the issued beat closes its line
  } fbrStrobes_t;

endpackage

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fbr_pkg::*;
#(
  parameter int LINES_W  = 10,
  parameter int PIXELS_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [LINES_W-1:0]  cfgLines,
  input  logic [PIXELS_W-1:0] cfgPixels,
  input  logic [LINES_W-1:0]  cfgStartRow,
  input  logic [PIXELS_W-1:0] cfgStartCol,
  input  logic                outValid,
  input  logic                outReady,
  output fbrStrobes_t         strb,
  output logic [LINES_W-1:0]  curRow,
  output logic [PIXELS_W-1:0] curCol,
  output logic [LINES_W-1:0]  baseRow,
  output logic [PIXELS_W-1:0] baseCol,
  output logic                done
);

  fbrState_t state;
  logic [LINES_W-1:0]  numLines;
  logic [PIXELS_W-1:0] numPixels;
  logic                isLastRow;

  assign isLastRow = (curRow == numLines - LINES_W'(1));

  always_comb begin
    strb.advance   = !outValid || outReady;
    strb.issue     = (state == ST_RUN) && strb.advance;
    strb.firstBeat = (curRow == '0) && (curCol == '0);
    strb.lineEnd   = (curCol == numPixels - PIXELS_W'(2));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curRow    <= '0;
      curCol    <= '0;
      numLines  <= '0;
      numPixels <= '0;
      baseRow   <= '0;
      baseCol   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            numLines  <= cfgLines;
            numPixels <= cfgPixels;
            baseRow   <= cfgStartRow;
            baseCol   <= cfgStartCol;
            curRow    <= '0;
            curCol    <= '0;
            state     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (strb.issue) begin
            if (strb.lineEnd) begin
              curCol <= '0;
              if (isLastRow) state <= ST_FLUSH;
              else curRow <= curRow + LINES_W'(1);
            end else begin
              curCol <= curCol + PIXELS_W'(2);
            end
          end
        end
        ST_FLUSH: begin
          if (outValid && outReady) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fbr_datapath.sv
module fbr_datapath
  import fbr_pkg::*;
#(
  parameter int PIX_W     = 16,
  parameter int MAX_WIDTH = 32,
  parameter int ADDR_W    = 9,
  parameter int LINES_W   = 10,
  parameter int PIXELS_W  = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [PIX_W-1:0]    wrData,
  input  fbrStrobes_t         strb,
  input  logic [LINES_W-1:0]  curRow,
  input  logic [PIXELS_W-1:0] curCol,
  input  logic [LINES_W-1:0]  baseRow,
  input  logic [PIXELS_W-1:0] baseCol,
  output logic [2*PIX_W-1:0]  outData,
  output logic                outValid,
  output logic                outUser,
  output logic                outLast
);

  localparam int BANK_W     = ADDR_W - 1;
  localparam int BANK_DEPTH = 1 << BANK_W;

  logic [ADDR_W-1:0] rowSum;
  logic [ADDR_W-1:0] linAddr;
  logic [BANK_W-1:0] wordIdx;
  logic              oddStart;
  logic              swapQ;

  always_comb begin
    rowSum   = ADDR_W'(curRow) + ADDR_W'(baseRow);
    linAddr  = rowSum * ADDR_W'(MAX_WIDTH) + ADDR_W'(curCol) + ADDR_W'(baseCol);
    wordIdx  = linAddr[ADDR_W-1:1];
    oddStart = linAddr[0];
  end

  // bank 0 holds even linear addresses, bank 1 holds odd ones
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [PIX_W-1:0]  mem [BANK_DEPTH];
    logic [PIX_W-1:0]  rdQ;
    logic [BANK_W-1:0] rdAddr;

    // an odd start takes the even-bank pixel from the following word
    assign rdAddr = wordIdx + ((b == 0) ? BANK_W'(oddStart) : BANK_W'(0));

    always_ff @(posedge clk) begin
      if (wrEn && (wrAddr[0] == 1'(b))) mem[wrAddr[ADDR_W-1:1]] <= wrData;
      if (strb.issue) rdQ <= mem[rdAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outUser  <= 1'b0;
      outLast  <= 1'b0;
      swapQ    <= 1'b0;
    end else if (strb.advance) begin
      outValid <= strb.issue;
      outUser  <= strb.issue && strb.firstBeat;
      outLast  <= strb.issue && strb.lineEnd;
      if (strb.issue) swapQ <= oddStart;
    end
  end

  assign outData = swapQ ? {g_bank[0].rdQ, g_bank[1].rdQ}
                         : {g_bank[1].rdQ, g_bank[0].rdQ};

endmodule

// File: rtl/fbr_reader.sv
module fbr_reader
  import fbr_pkg::*;
#(
  parameter int PIX_W      = 16,
  parameter int MAX_WIDTH  = 32,
  parameter int MAX_HEIGHT = 16,
  parameter int LINES_W    = 10,
  parameter int PIXELS_W   = 11,
  localparam int ADDR_W    = $clog2(MAX_WIDTH * MAX_HEIGHT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [PIX_W-1:0]    wrData,
  input  logic                start,
  input  logic [LINES_W-1:0]  cfgLines,
  input  logic [PIXELS_W-1:0] cfgPixels,
  input  logic [LINES_W-1:0]  cfgStartRow,
  input  logic [PIXELS_W-1:0] cfgStartCol,
  output logic [2*PIX_W-1:0]  outData,
  output logic                outValid,
  input  logic                outReady,
  output logic                outUser,
  output logic                outLast,
  output logic                done
);

  fbrStrobes_t         strb;
  logic [LINES_W-1:0]  curRow;
  logic [PIXELS_W-1:0] curCol;
  logic [LINES_W-1:0]  baseRow;
  logic [PIXELS_W-1:0] baseCol;

  fbr_ctrl #(.LINES_W(LINES_W), .PIXELS_W(PIXELS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgLines(cfgLines), .cfgPixels(cfgPixels),
    .cfgStartRow(cfgStartRow), .cfgStartCol(cfgStartCol),
    .outValid(outValid), .outReady(outReady),
    .strb(strb), .curRow(curRow), .curCol(curCol),
    .baseRow(baseRow), .baseCol(baseCol), .done(done)
  );

  fbr_datapath #(
    .PIX_W(PIX_W), .MAX_WIDTH(MAX_WIDTH), .ADDR_W(ADDR_W),
    .LINES_W(LINES_W), .PIXELS_W(PIXELS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .curRow(curRow), .curCol(curCol),
    .baseRow(baseRow), .baseCol(baseCol),
    .outData(outData), .outValid(outValid),
    .outUser(outUser), .outLast(outLast)
  );

endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] outData,
  input logic              outValid,
  input logic              outReady,
  input logic              outUser,
  input logic              outLast,
  input logic              done
);

  // R8: a stalled beat keeps its payload and flags
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outUser) && $stable(outLast)));

  // R5: the beat after an accepted first beat never carries the user flag
  p_user_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outUser) |=> !outUser);

  // R7: inside a line an accepted beat is followed at once by the next one
  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outLast) |=> outValid);

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done only follows the acceptance of a line-closing beat
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(outValid && outReady && outLast));

  // R9: nothing is presented while done is high
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

endmodule

bind fbr_reader fbr_checker #(.DATA_W(2 * PIX_W)) u_fbr_checker (
  .clk(clk), .rstN(rstN), .outData(outData), .outValid(outValid),
  .outReady(outReady), .outUser(outUser), .outLast(outLast), .done(done)
);

// File: tb/test_fbr_reader.sv
module test_fbr_reader;

  localparam int MAXW  = 32;
  localparam int MAXH  = 16;
  localparam int DEPTH = MAXW * MAXH;

  typedef struct packed {
    logic [31:0] data;
    logic        user;
    logic        last;
  } beat_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [8:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        start = 1'b0;
  logic [9:0]  cfgLines = '0;
  logic [10:0] cfgPixels = '0;
  logic [9:0]  cfgStartRow = '0;
  logic [10:0] cfgStartCol = '0;
  logic [31:0] outData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        outUser;
  logic        outLast;
  logic        done;

  int    nChecks = 0;
  int    nFails = 0;
  beat_t expQ[$];
  bit    stallMode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  int    cyc = 0;
  int    firstAcc = -1;
  int    lastAcc = -1;
  bit    prevValid = 1'b0, prevReady = 1'b0, prevAccLast = 1'b0, prevDone = 1'b0;
  logic [31:0] prevData = '0;
  logic  prevUser = 1'b0, prevLast = 1'b0;

  fbr_reader i_fbr_reader (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .start(start), .cfgLines(cfgLines), .cfgPixels(cfgPixels),
    .cfgStartRow(cfgStartRow), .cfgStartCol(cfgStartCol),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outUser(outUser), .outLast(outLast), .done(done)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] pix(input int a);
    return 16'(a * 97 + 12345);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk) begin
    #1 outReady = stallMode ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (prevValid && !prevReady)
        check(outValid && outData == prevData && outUser == prevUser && outLast == prevLast,
              "R8", "stalled beat changed", {outValid, outUser, outLast, outData},
              {3'b100 | {1'b0, prevUser, prevLast}, prevData});
      if (done) begin
        check(prevAccLast, "R9", "done without final accept", 64'(prevAccLast), 64'd1);
        check(!prevDone, "R9", "done longer than one cycle", 64'(prevDone), 64'd0);
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "unexpected beat", 64'(outData), 64'd0);
        end else begin
          beat_t e;
          e = expQ.pop_front();
          check(outData == e.data, "R2/R3/R4", "pixel pair", 64'(outData), 64'(e.data));
          check(outUser == e.user, "R5", "user flag", 64'(outUser), 64'(e.user));
          check(outLast == e.last, "R6", "last flag", 64'(outLast), 64'(e.last));
        end
        if (firstAcc < 0) firstAcc = cyc;
        lastAcc = cyc;
      end
    end
    prevValid   = outValid;
    prevReady   = outReady;
    prevData    = outData;
    prevUser    = outUser;
    prevLast    = outLast;
    prevAccLast = outValid && outReady && outLast;
    prevDone    = done;
  end

  task automatic runFrame(input int ln, input int px, input int sr, input int sc,
                          input bit stall, input bit poke);
    int t;
    int beats;
    beats = ln * px / 2;
    for (int y = 0; y < ln; y++) begin
      for (int x = 0; x < px; x += 2) begin
        beat_t e;
        int a;
        a = (y + sr) * MAXW + x + sc;
        e.data = {pix(a + 1), pix(a)};
        e.user = (y == 0 && x == 0);
        e.last = (x == px - 2);
        expQ.push_back(e);
      end
    end
    stallMode = stall;
    firstAcc = -1;
    lastAcc = -1;
    @(negedge clk);
    cfgLines = 10'(ln); cfgPixels = 11'(px);
    cfgStartRow = 10'(sr); cfgStartCol = 11'(sc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      cfgLines = 10'd2; cfgPixels = 11'd4; cfgStartRow = 10'd1; cfgStartCol = 11'd1;
      start = 1'b1;  // R10: must be ignored mid-frame
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(done, "R9", "done seen", 64'(done), 64'd1);
    check(expQ.size() == 0, "R9", "beats left at done", 64'(expQ.size()), 64'd0);
    if (!stall)
      check(lastAcc - firstAcc + 1 == beats, "R7", "cycles for frame",
            64'(lastAcc - firstAcc + 1), 64'(beats));
    stallMode = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!outValid && !done, poke ? "R10" : "R9", "idle after frame",
            {62'd0, outValid, done}, 64'd0);
    end
    expQ.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R7 watchdog expired: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && !done, "R1", "in reset", {62'd0, outValid, done}, 64'd0);
    rstN = 1'b1;
    // load image through the write port (R2)
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 9'(a); wrData = pix(a);
    end
    @(negedge clk);
    wrEn = 1'b0;
    check(!outValid && !done, "R1", "idle before start", {62'd0, outValid, done}, 64'd0);

    runFrame(3, 8, 2, 4, 1'b0, 1'b0);   // R3 even offset, full rate R7
    runFrame(2, 6, 0, 3, 1'b1, 1'b0);   // R4 odd start, stalls R8
    runFrame(4, 32, 10, 0, 1'b0, 1'b1); // full pitch, R10 start during frame
    runFrame(1, 2, 7, 9, 1'b0, 1'b0);   // single beat: user and last together
    runFrame(5, 10, 3, 5, 1'b1, 1'b0);  // odd start with stalls across lines

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule